// File: doc/BRIEF.md
# Serial Management Bus Slave

This block is the target side of a slow three-wire management link. The master supplies a serial clock of no more than 1 MHz, a command line that marks where frames start, and one bidirectional data line. Here the data line is split into an input, an output and an output enable, so the pad stays outside the block. Each frame carries an operation code, a device select, an address and a data word. The code chooses one of four actions. Two of them read or write a bank of 16-bit control registers inside the block. The other two hand a one-byte write or a one-byte random read of the memory-module presence-detect EEPROM to a request/acknowledge side port.

The slave runs entirely in the serial clock domain. The command line is sampled on both edges of the serial clock. A single high sample at a rising edge, after a low one, opens a frame. Holding the line high for a long run is a line reset: it aborts any frame in progress. EEPROM work is deferred. The frame raises a request, and the completion of that request is reported through done flags and a captured read byte in a status register. The master reads that status register with an ordinary register read.

Top module: `sctl_slave`

## Requirements
- R1: A frame opens at a rising edge where `cmdIn` is high and was low at the previous rising edge. The frame is 35 bits on `sdaIn`, one bit per rising edge, with the opening edge taking the first bit. The order is opcode[3:0], device[2:0], address[11:0], data[15:0], each field MSB first.
- R2: Opcode 4'b0001 writes the data word into control register `address` when address < NREG (default 8). The write is applied at the rising edge of the last data bit. An address at or above NREG that is not the status address is left unwritten.
- R3: For opcode 4'b0000, `sdaOe` rises after the rising edge that takes the last address bit and stays high for exactly 16 clock periods. During those periods `sdaOut` presents the addressed value MSB first, one new bit after each rising edge. At all other times `sdaOe` is low.
- R4: A read of an address that is neither a control register nor the status address returns 16'h0000.
- R5: The status register sits at address 12'h0F0. Bit 15 is write-done, bit 14 is read-done, bits 7:0 hold the last byte returned by the EEPROM, and the other bits read 0. A write frame aimed at this address leaves it unchanged.
- R6: Opcode 4'b1101 clears write-done and raises `eeReq` with `eeWrite`=1, `eeDev`=device, `eeAddr`=address[7:0] and `eeWdata`=data[7:0].
- R7: Opcode 4'b1110 clears read-done and raises `eeReq` with `eeWrite`=0, `eeDev`=device and `eeAddr`=address[7:0]. The data field of this frame is ignored.
- R8: `eeReq` and its fields hold steady until a rising edge with `eeAck` high. After that edge `eeReq` is low. For a write request, write-done is set. For a read request, read-done is set and `eeRdata` is stored as the status read byte.
- R9: An EEPROM command that completes while `eeReq` is still high is dropped. It leaves the pending request and both done flags untouched.
- R10: Any opcode other than 0000, 0001, 1101 and 1110 causes the rest of the frame to be ignored. Registers, status and `eeReq` keep their values.
- R11: Eight consecutive high samples of `cmdIn`, counted across both clock edges, return the frame logic to idle at the next rising edge. This discards the frame in progress and leaves register and status contents as they were. Six consecutive high samples do not abort a frame.
- R12: After `rstN` is asserted, every control register and both done flags are 0, the read byte is 0, and `eeReq` and `sdaOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock from the bus master |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdIn | input | 1 | Command line: frame start and line reset |
| sdaIn | input | 1 | Data line, input side |
| sdaOut | output | 1 | Data line, output side (meaningful while sdaOe is high) |
| sdaOe | output | 1 | Data line output enable |
| eeReq | output | 1 | EEPROM operation request |
| eeWrite | output | 1 | 1 for a byte write, 0 for a random read |
| eeDev | output | 3 | EEPROM device select |
| eeAddr | output | 8 | EEPROM byte address |
| eeWdata | output | 8 | Byte to write |
| eeAck | input | 1 | Completion acknowledge from the EEPROM side |
| eeRdata | input | 8 | Byte returned by a read, valid with eeAck |

## Verification
Register traffic uses distinct bit patterns at two in-range addresses, so a swapped bit order, a shifted output window or a wrong register index shows up as a wrong readback. Out-of-range, status-address and reserved-opcode frames test whether a write is wrongly accepted. EEPROM frames are checked on the side port before and after acknowledge, with one command issued while a request is still pending to separate queuing from dropping. Command pulses of six and eight high samples fall on either side of the line-reset threshold, so a counter that ignores the falling-edge samples or counts one off gives the wrong outcome.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int OP_W   = 4;
  localparam int DEV_W  = 3;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int HDR_W  = OP_W + DEV_W + ADDR_W;

  localparam logic [OP_W-1:0] OP_REG_RD = 4'b0000;
  localparam logic [OP_W-1:0] OP_REG_WR = 4'b0001;
  localparam logic [OP_W-1:0] OP_EE_WR  = 4'b1101;
  localparam logic [OP_W-1:0] OP_EE_RD  = 4'b1110;

  // strobes from control to datapath, one rising edge each
  typedef struct packed {
    logic capHdr;    // shift a header bit in
    logic latchHdr;  // header complete: latch fields, load read word
    logic capData;   // shift a data bit in
    logic commit;    // last data bit: perform the write or EEPROM launch
    logic shiftOut;  // advance the read shifter
  } strobe_t;

  function automatic logic opKnown(input logic [OP_W-1:0] op);
    return (op == OP_REG_RD) || (op == OP_REG_WR) ||
           (op == OP_EE_WR) || (op == OP_EE_RD);
  endfunction
endpackage

// File: rtl/sctl_ctrl.sv
module sctl_ctrl
  import sctl_pkg::*;
#(
  parameter int RESET_RUN = 8
) (
  input  logic            sck,
  input  logic            rstN,
  input  logic            cmdIn,
  input  logic [OP_W-1:0] opcode,
  output strobe_t         stb,
  output logic            drive
);
  localparam int RUN_W = $clog2(RESET_RUN + 2) + 1;
  localparam int CNT_W = $clog2(HDR_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_SKIP, S_OUT} state_e;

  state_e     state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [RUN_W-1:0] highRun, negRun, posRun;
  logic       cmdNeg, cmdPrev, lineReset, start;

  // falling-edge sample of the command line
  always_ff @(negedge sck or negedge rstN) begin
    if (!rstN) cmdNeg <= 1'b0;
    else       cmdNeg <= cmdIn;
  end

  // run of consecutive high samples, both edges counted
  always_comb begin
    negRun    = cmdNeg ? highRun + RUN_W'(1) : '0;
    posRun    = cmdIn  ? negRun  + RUN_W'(1) : '0;
    lineReset = (negRun >= RUN_W'(RESET_RUN)) || (posRun >= RUN_W'(RESET_RUN));
    start     = (state == S_IDLE) && cmdIn && !cmdPrev;
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    stb       = '0;
    unique case (state)
      S_IDLE: if (start) begin
        stb.capHdr = 1'b1;
        stateNext  = S_HDR;
        cntNext    = CNT_W'(1);
      end
      S_HDR: begin
        stb.capHdr = 1'b1;
        if (cnt == CNT_W'(HDR_W - 1)) begin
          stb.latchHdr = 1'b1;
          cntNext      = '0;
          if (opcode == OP_REG_RD)  stateNext = S_OUT;
          else if (opKnown(opcode)) stateNext = S_DATA;
          else                      stateNext = S_SKIP;
        end else cntNext = cnt + CNT_W'(1);
      end
      S_DATA: begin
        stb.capData = 1'b1;
        if (cnt == CNT_W'(DATA_W - 1)) begin
          stb.commit = 1'b1;
          stateNext  = S_IDLE;
        end else cntNext = cnt + CNT_W'(1);
      end
      S_SKIP: begin
        if (cnt == CNT_W'(DATA_W - 1)) stateNext = S_IDLE;
        else cntNext = cnt + CNT_W'(1);
      end
      S_OUT: begin
        stb.shiftOut = 1'b1;
        if (cnt == CNT_W'(DATA_W - 1)) stateNext = S_IDLE;
        else cntNext = cnt + CNT_W'(1);
      end
      default: stateNext = S_IDLE;
    endcase
    if (lineReset) begin
      stb       = '0;
      stateNext = S_IDLE;
      cntNext   = '0;
    end
  end

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      highRun <= '0;
      cmdPrev <= 1'b1;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      highRun <= (posRun > RUN_W'(RESET_RUN)) ? RUN_W'(RESET_RUN) : posRun;
      cmdPrev <= cmdIn;
    end
  end

  assign drive = (state == S_OUT);
endmodule

// File: rtl/sctl_dp.sv
module sctl_dp
  import sctl_pkg::*;
#(
  parameter int               NREG        = 8,
  parameter logic [11:0]      STATUS_ADDR = 12'h0F0
) (
  input  logic              sck,
  input  logic              rstN,
  input  logic              sdaIn,
  input  strobe_t           stb,
  output logic [OP_W-1:0]   opcode,
  output logic              sdaOut,
  output logic              eeReq,
  output logic              eeWrite,
  output logic [DEV_W-1:0]  eeDev,
  output logic [7:0]        eeAddr,
  output logic [7:0]        eeWdata,
  input  logic              eeAck,
  input  logic [7:0]        eeRdata
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [HDR_W-2:0]  hdrSh;
  logic [HDR_W-1:0]  hdrFull;
  logic [DATA_W-2:0] dataSh;
  logic [DATA_W-1:0] dataFull, outReg, readVal, statusWord;
  logic [OP_W-1:0]   opReg;
  logic [DEV_W-1:0]  devReg;
  logic [ADDR_W-1:0] addrReg, addrFull;
  logic [DATA_W-1:0] regs [NREG];
  logic              wrDone, rdDone, eeLaunch, regWrite;
  logic [7:0]        rdByte;

  assign hdrFull    = {hdrSh, sdaIn};
  assign dataFull   = {dataSh, sdaIn};
  assign addrFull   = hdrFull[ADDR_W-1:0];
  assign opcode     = hdrSh[HDR_W-2 -: OP_W];
  assign statusWord = {wrDone, rdDone, 6'b0, rdByte};
  assign sdaOut     = outReg[DATA_W-1];
  assign regWrite   = stb.commit && (opReg == OP_REG_WR) && (addrReg < ADDR_W'(NREG));
  assign eeLaunch   = stb.commit && ((opReg == OP_EE_WR) || (opReg == OP_EE_RD)) && !eeReq;

  always_comb begin
    if (addrFull < ADDR_W'(NREG))     readVal = regs[addrFull[IDX_W-1:0]];
    else if (addrFull == STATUS_ADDR) readVal = statusWord;
    else                              readVal = '0;
  end

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      hdrSh   <= '0;
      dataSh  <= '0;
      opReg   <= '0;
      devReg  <= '0;
      addrReg <= '0;
      outReg  <= '0;
    end else begin
      if (stb.capHdr)  hdrSh  <= {hdrSh[HDR_W-3:0], sdaIn};
      if (stb.capData) dataSh <= {dataSh[DATA_W-3:0], sdaIn};
      if (stb.latchHdr) begin
        opReg   <= hdrFull[HDR_W-1 -: OP_W];
        devReg  <= hdrFull[ADDR_W +: DEV_W];
        addrReg <= addrFull;
        outReg  <= readVal;
      end else if (stb.shiftOut) begin
        outReg <= {outReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : gReg
      always_ff @(posedge sck or negedge rstN) begin
        if (!rstN) regs[g] <= '0;
        else if (regWrite && (addrReg[IDX_W-1:0] == IDX_W'(g))) regs[g] <= dataFull;
      end
    end
  endgenerate

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      eeReq   <= 1'b0;
      eeWrite <= 1'b0;
      eeDev   <= '0;
      eeAddr  <= '0;
      eeWdata <= '0;
      wrDone  <= 1'b0;
      rdDone  <= 1'b0;
      rdByte  <= '0;
    end else if (eeLaunch) begin
      eeReq   <= 1'b1;
      eeWrite <= (opReg == OP_EE_WR);
      eeDev   <= devReg;
      eeAddr  <= addrReg[7:0];
      eeWdata <= dataFull[7:0];
      if (opReg == OP_EE_WR) wrDone <= 1'b0;
      else                   rdDone <= 1'b0;
    end else if (eeReq && eeAck) begin
      eeReq <= 1'b0;
      if (eeWrite) wrDone <= 1'b1;
      else begin
        rdDone <= 1'b1;
        rdByte <= eeRdata;
      end
    end
  end
endmodule

// File: rtl/sctl_slave.sv
module sctl_slave
  import sctl_pkg::*;
#(
  parameter int          NREG        = 8,
  parameter logic [11:0] STATUS_ADDR = 12'h0F0,
  parameter int          RESET_RUN   = 8
) (
  input  logic       sck,
  input  logic       rstN,
  input  logic       cmdIn,
  input  logic       sdaIn,
  output logic       sdaOut,
  output logic       sdaOe,
  output logic       eeReq,
  output logic       eeWrite,
  output logic [2:0] eeDev,
  output logic [7:0] eeAddr,
  output logic [7:0] eeWdata,
  input  logic       eeAck,
  input  logic [7:0] eeRdata
);
  strobe_t         stb;
  logic [OP_W-1:0] opcode;

  sctl_ctrl #(.RESET_RUN(RESET_RUN)) u_ctrl (
    .sck(sck), .rstN(rstN), .cmdIn(cmdIn), .opcode(opcode),
    .stb(stb), .drive(sdaOe)
  );

  sctl_dp #(.NREG(NREG), .STATUS_ADDR(STATUS_ADDR)) u_dp (
    .sck(sck), .rstN(rstN), .sdaIn(sdaIn), .stb(stb), .opcode(opcode),
    .sdaOut(sdaOut), .eeReq(eeReq), .eeWrite(eeWrite), .eeDev(eeDev),
    .eeAddr(eeAddr), .eeWdata(eeWdata), .eeAck(eeAck), .eeRdata(eeRdata)
  );
endmodule

// File: rtl/sctl_slave_chk.sv
module sctl_slave_chk (
  input logic       sck,
  input logic       rstN,
  input logic       sdaOe,
  input logic       eeReq,
  input logic       eeAck,
  input logic       eeWrite,
  input logic [2:0] eeDev,
  input logic [7:0] eeAddr,
  input logic [7:0] eeWdata
);
  logic [5:0] oeRun;

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN)      oeRun <= '0;
    else if (sdaOe) oeRun <= (oeRun == 6'd63) ? oeRun : oeRun + 6'd1;
    else            oeRun <= '0;
  end

  AST_REQ_HOLD: assert property (@(posedge sck) disable iff (!rstN)
    (eeReq && !eeAck) |=> eeReq); // R8
  AST_REQ_DROP: assert property (@(posedge sck) disable iff (!rstN)
    (eeReq && eeAck) |=> !eeReq); // R8
  AST_REQ_STABLE: assert property (@(posedge sck) disable iff (!rstN)
    (eeReq && !eeAck) |=> $stable({eeWrite, eeDev, eeAddr, eeWdata})); // R8
  AST_OE_WINDOW_MAX: assert property (@(posedge sck) disable iff (!rstN)
    oeRun <= 6'd16); // R3
endmodule

bind sctl_slave sctl_slave_chk u_chk (
  .sck(sck), .rstN(rstN), .sdaOe(sdaOe), .eeReq(eeReq), .eeAck(eeAck),
  .eeWrite(eeWrite), .eeDev(eeDev), .eeAddr(eeAddr), .eeWdata(eeWdata)
);

// File: tb/sctl_slave_tb.sv
module sctl_slave_tb;
  logic       sck = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdIn = 1'b0;
  logic       sdaIn = 1'b0;
  logic       sdaOut, sdaOe, eeReq, eeWrite;
  logic [2:0] eeDev;
  logic [7:0] eeAddr, eeWdata;
  logic       eeAck = 1'b0;
  logic [7:0] eeRdata = 8'h00;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  sctl_slave u_dut (
    .sck(sck), .rstN(rstN), .cmdIn(cmdIn), .sdaIn(sdaIn), .sdaOut(sdaOut),
    .sdaOe(sdaOe), .eeReq(eeReq), .eeWrite(eeWrite), .eeDev(eeDev),
    .eeAddr(eeAddr), .eeWdata(eeWdata), .eeAck(eeAck), .eeRdata(eeRdata)
  );

  always #2 sck = ~sck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame; inputs change 1 ns after a falling edge, outputs read at it
  task automatic frame(input logic [3:0] op, input logic [2:0] dev,
                       input logic [11:0] addr, input logic [15:0] data,
                       input int cmdLen, output logic [15:0] rd, output bit oeBad);
    logic [34:0] v;
    v = {op, dev, addr, data};
    rd = '0;
    oeBad = 0;
    for (int i = 0; i < 35; i++) begin
      @(negedge sck);
      if (i >= 19) begin
        rd[15-(i-19)] = sdaOut;
        if (sdaOe !== (op == 4'b0000)) oeBad = 1;
      end else if (sdaOe !== 1'b0) oeBad = 1;
      #1;
      cmdIn = (i < cmdLen);
      sdaIn = v[34-i];
    end
    @(negedge sck);
    if (sdaOe !== 1'b0) oeBad = 1;
    #1;
    cmdIn = 1'b0;
    sdaIn = 1'b0;
    @(negedge sck);
  endtask

  task automatic regWr(input logic [11:0] addr, input logic [15:0] data);
    logic [15:0] rd;
    bit oeBad;
    frame(4'b0001, 3'd0, addr, data, 1, rd, oeBad);
  endtask

  task automatic regRd(input string req, input logic [11:0] addr, input logic [15:0] exp);
    logic [15:0] rd;
    bit oeBad;
    frame(4'b0000, 3'd0, addr, 16'h0000, 1, rd, oeBad);
    chk(req, {16'h0, rd}, {16'h0, exp});
    chk({req, " R3 oe window"}, {31'h0, oeBad}, 32'h0);
  endtask

  task automatic ack(input logic [7:0] rdata);
    @(negedge sck);
    #1;
    eeAck = 1'b1;
    eeRdata = rdata;
    @(negedge sck);
    chk("R8 req drops after ack", {31'h0, eeReq}, 32'h0);
    #1;
    eeAck = 1'b0;
  endtask

  task automatic testReset();
    chk("R12 oe at reset", {31'h0, sdaOe}, 32'h0);
    chk("R12 req at reset", {31'h0, eeReq}, 32'h0);
    regRd("R12 reg0 at reset", 12'h000, 16'h0000);
    regRd("R12 status at reset", 12'h0F0, 16'h0000);
  endtask

  task automatic testRegs();
    regWr(12'h003, 16'hA5C3);
    regWr(12'h007, 16'h1234);
    regRd("R1 R2 reg3", 12'h003, 16'hA5C3);
    regRd("R2 reg7", 12'h007, 16'h1234);
    regWr(12'h008, 16'hFFFF);
    regRd("R4 unmapped read", 12'h008, 16'h0000);
    regRd("R2 reg0 untouched", 12'h000, 16'h0000);
  endtask

  task automatic testReserved();
    logic [15:0] rd;
    bit oeBad;
    frame(4'b0101, 3'd0, 12'h003, 16'h0000, 1, rd, oeBad);
    frame(4'b0010, 3'd1, 12'h007, 16'hFFFF, 1, rd, oeBad);
    frame(4'b1111, 3'd1, 12'h0AB, 16'h00FF, 1, rd, oeBad);
    chk("R10 no request", {31'h0, eeReq}, 32'h0);
    regRd("R10 reg3 kept", 12'h003, 16'hA5C3);
    regRd("R10 reg7 kept", 12'h007, 16'h1234);
  endtask

  task automatic testEeprom();
    logic [15:0] rd;
    bit oeBad;
    frame(4'b1101, 3'd5, 12'h1AB, 16'h1234, 1, rd, oeBad);
    chk("R6 req", {31'h0, eeReq}, 32'h1);
    chk("R6 fields", {13'h0, eeWrite, eeDev, eeAddr, eeWdata}, {13'h0, 1'b1, 3'd5, 8'hAB, 8'h34});
    frame(4'b1110, 3'd2, 12'h07E, 16'h0000, 1, rd, oeBad);
    chk("R9 pending kept", {13'h0, eeWrite, eeDev, eeAddr, eeWdata}, {13'h0, 1'b1, 3'd5, 8'hAB, 8'h34});
    ack(8'h55);
    regRd("R8 write done", 12'h0F0, 16'h8000);
    frame(4'b1110, 3'd2, 12'h07E, 16'hFFFF, 1, rd, oeBad);
    chk("R7 req", {31'h0, eeReq}, 32'h1);
    chk("R7 fields", {20'h0, eeWrite, eeDev, eeAddr}, {20'h0, 1'b0, 3'd2, 8'h7E});
    ack(8'h9C);
    regRd("R8 read done and byte", 12'h0F0, 16'hC09C);
    frame(4'b1101, 3'd1, 12'h010, 16'h00EE, 1, rd, oeBad);
    regRd("R6 write done cleared", 12'h0F0, 16'h409C);
    ack(8'h00);
    regRd("R8 status after second write", 12'h0F0, 16'hC09C);
    regWr(12'h0F0, 16'h0000);
    regRd("R5 status write ignored", 12'h0F0, 16'hC09C);
  endtask

  task automatic testLineReset();
    logic [15:0] rd;
    bit oeBad;
    frame(4'b0001, 3'd0, 12'h003, 16'hBEEF, 4, rd, oeBad);
    regRd("R11 eight samples abort", 12'h003, 16'hA5C3);
    frame(4'b0001, 3'd0, 12'h005, 16'h0F0F, 3, rd, oeBad);
    regRd("R11 six samples keep frame", 12'h005, 16'h0F0F);
    regRd("R11 status kept", 12'h0F0, 16'hC09C);
  endtask

  initial begin
    repeat (3) @(negedge sck);
    #1 rstN = 1'b1;
    repeat (2) @(negedge sck);
    testReset();
    testRegs();
    testReserved();
    testEeprom();
    testLineReset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule